// File: doc/BRIEF.md
# Receiver Standby Power Controller

This block holds an 8-bit standby control word for a mixed-signal receiver. Each bit that is set keeps one functional block of the receiver in standby. A bit that is cleared lets that block power up. The word is written and read over a plain parallel register bus that gives one write strobe and one read strobe per clock. Serial framing of the register bus happens elsewhere.

From the stored word the block derives the enables that depend on more than one bit:
- The shared clock buffer shuts down only when both of the blocks that use it are in standby.
- The digital-filter clock gate and the output-hold flag follow ADC standby.
- The output-enables for the two charge-pump current outputs follow their synthesizers.
- A master reference goes into standby only when every used block is in standby.

All derived signals are combinational from the stored word, so they change in the cycle after a write.

Top module: `rx_stby_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, the word reads 0xFF. Every per-block standby output is 1, `clkbuf_off` is 1, `master_ref_off` is 1, `filt_clk_en` is 0, `dout_hold` is 1, and both current-output enables are 0.
- R2: When `wr_en` is 1 at a rising edge, the word takes `wr_data`. From the next cycle the standby outputs follow it with this fixed bit map:
  - bit 7 drives `ref_off`
  - bit 6 drives `lo_off`
  - bit 5 drives `osc_off`
  - bit 4 drives `clksyn_off`
  - bit 3 drives `gcdac_off`
  - bit 2 drives `lnamix_off`
  - bit 0 drives `adc_off`
- R3: When `rd_en` is 1 at a rising edge, `rd_valid` is 1 in the following cycle and `rd_data` carries the word. In a cycle that follows no read, `rd_valid` is 0.
- R4: When `rd_en` and `wr_en` are both 1 at the same edge, `rd_data` returns the word as it was before that write. The write still takes effect.
- R5: `clkbuf_off` is 1 exactly when bit 0 and bit 4 are both 1.
- R6: When bit 0 is 1, `filt_clk_en` is 0 and `dout_hold` is 1. When bit 0 is 0, `filt_clk_en` is 1 and `dout_hold` is 0.
- R7: `master_ref_off` is 1 exactly when bits 7, 6, 5, 4, 3, 2 and 0 are all 1. Bit 1 does not matter.
- R8: `lo_iout_oe` is the inverse of bit 6, and `clk_iout_oe` is the inverse of bit 4. An enable of 0 means the output is three-stated.
- R9: Bit 1 is stored and read back as written. Changing it alone leaves every derived output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 8 | Read data |
| ref_off | output | 1 | Voltage reference standby |
| lo_off | output | 1 | LO synthesizer standby |
| osc_off | output | 1 | Clock oscillator standby |
| clksyn_off | output | 1 | Clock synthesizer standby |
| gcdac_off | output | 1 | Gain-control DAC standby |
| lnamix_off | output | 1 | LNA and mixer standby |
| adc_off | output | 1 | ADC standby |
| clkbuf_off | output | 1 | Shared clock buffer standby |
| filt_clk_en | output | 1 | Digital-filter clock enable |
| dout_hold | output | 1 | Freeze the digital outputs |
| master_ref_off | output | 1 | Master reference standby |
| lo_iout_oe | output | 1 | LO charge-pump current output enable |
| clk_iout_oe | output | 1 | Clock charge-pump current output enable |

## Verification
A read and a write can hit the same edge. The question is whether `rd_data` then returns the old word or the new one. The bench issues both strobes together, with write data that differs from the stored word in several bits, including bit 1 and the bits feeding the shared clock buffer. A model updated only at the edge predicts that `rd_data` holds the pre-write word, while every derived output shows the post-write word. This is compared on every clock, along with a pseudo-random run in which the two strobes overlap often.

// File: rtl/rx_stby_pkg.sv
package rx_stby_pkg;
  localparam int STBY_W     = 8;
  localparam int B_REF      = 7;
  localparam int B_LO       = 6;
  localparam int B_OSC      = 5;
  localparam int B_CLKSYN   = 4;
  localparam int B_GCDAC    = 3;
  localparam int B_LNAMIX   = 2;
  localparam int B_SPARE    = 1;
  localparam int B_ADC      = 0;
  localparam logic [STBY_W-1:0] STBY_RESET = '1;
  localparam logic [STBY_W-1:0] USED_MASK  = ~(STBY_W'(1) << B_SPARE);

  typedef struct packed {
    logic ref_off;
    logic lo_off;
    logic osc_off;
    logic clksyn_off;
    logic gcdac_off;
    logic lnamix_off;
    logic adc_off;
    logic clkbuf_off;
    logic filt_clk_en;
    logic dout_hold;
    logic master_ref_off;
    logic lo_iout_oe;
    logic clk_iout_oe;
  } stby_ctl_t;
endpackage

// File: rtl/rx_stby_word.sv
module rx_stby_word
  import rx_stby_pkg::*;
#(
  parameter int W = STBY_W,
  parameter logic [W-1:0] RST_VAL = STBY_RESET
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= RST_VAL;
    end else if (wr_en) begin
      word <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= word;
    end
  end

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> word == $past(wr_data));
  a_r3_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  a_r3_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  a_r4_read_sees_old: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en) |=> rd_data == $past(word));
endmodule

// File: rtl/rx_stby_decode.sv
module rx_stby_decode
  import rx_stby_pkg::*;
#(
  parameter int W = STBY_W,
  parameter logic [W-1:0] MASK = USED_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] word,
  output stby_ctl_t    ctl
);
  logic [W-1:0] used_bits;

  generate
    for (genvar i = 0; i < W; i++) begin : g_mask
      if (MASK[i]) begin : g_use
        assign used_bits[i] = word[i];
      end else begin : g_skip
        assign used_bits[i] = 1'b1;
      end
    end
  endgenerate

  always_comb begin
    ctl.ref_off        = word[B_REF];
    ctl.lo_off         = word[B_LO];
    ctl.osc_off        = word[B_OSC];
    ctl.clksyn_off     = word[B_CLKSYN];
    ctl.gcdac_off      = word[B_GCDAC];
    ctl.lnamix_off     = word[B_LNAMIX];
    ctl.adc_off        = word[B_ADC];
    ctl.clkbuf_off     = word[B_ADC] & word[B_CLKSYN];
    ctl.filt_clk_en    = ~word[B_ADC];
    ctl.dout_hold      = word[B_ADC];
    ctl.master_ref_off = &used_bits;
    ctl.lo_iout_oe     = ~word[B_LO];
    ctl.clk_iout_oe    = ~word[B_CLKSYN];
  end

  a_r5_buffer_kept_for_user: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.adc_off || !ctl.clksyn_off) |-> !ctl.clkbuf_off);
  a_r6_filter_clock_gated: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.adc_off |-> (!ctl.filt_clk_en && ctl.dout_hold));
  a_r7_master_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.master_ref_off |-> (ctl.ref_off && ctl.lo_off && ctl.osc_off && ctl.clksyn_off
                            && ctl.gcdac_off && ctl.lnamix_off && ctl.adc_off));
  a_r8_lo_tristate: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.lo_off |-> !ctl.lo_iout_oe);
  a_r9_spare_inert: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(word) ^ word) == (W'(1) << B_SPARE) |-> $stable(ctl));
endmodule

// File: rtl/rx_stby_ctrl.sv
module rx_stby_ctrl
  import rx_stby_pkg::*;
#(
  parameter int W = STBY_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  output logic         ref_off,
  output logic         lo_off,
  output logic         osc_off,
  output logic         clksyn_off,
  output logic         gcdac_off,
  output logic         lnamix_off,
  output logic         adc_off,
  output logic         clkbuf_off,
  output logic         filt_clk_en,
  output logic         dout_hold,
  output logic         master_ref_off,
  output logic         lo_iout_oe,
  output logic         clk_iout_oe
);
  logic [W-1:0] word;
  stby_ctl_t    ctl;

  rx_stby_word #(.W(W)) u_word (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data), .word(word)
  );

  rx_stby_decode #(.W(W)) u_decode (
    .clk(clk), .rst_n(rst_n), .word(word), .ctl(ctl)
  );

  assign ref_off        = ctl.ref_off;
  assign lo_off         = ctl.lo_off;
  assign osc_off        = ctl.osc_off;
  assign clksyn_off     = ctl.clksyn_off;
  assign gcdac_off      = ctl.gcdac_off;
  assign lnamix_off     = ctl.lnamix_off;
  assign adc_off        = ctl.adc_off;
  assign clkbuf_off     = ctl.clkbuf_off;
  assign filt_clk_en    = ctl.filt_clk_en;
  assign dout_hold      = ctl.dout_hold;
  assign master_ref_off = ctl.master_ref_off;
  assign lo_iout_oe     = ctl.lo_iout_oe;
  assign clk_iout_oe    = ctl.clk_iout_oe;

  a_r1_reset_all_standby: assert property (@(posedge clk)
    !rst_n |=> (rst_n || (master_ref_off && clkbuf_off && !filt_clk_en)));
endmodule

// File: tb/test_rx_stby_ctrl.sv
module test_rx_stby_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic ref_off, lo_off, osc_off, clksyn_off, gcdac_off, lnamix_off, adc_off;
  logic clkbuf_off, filt_clk_en, dout_hold, master_ref_off, lo_iout_oe, clk_iout_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rx_stby_ctrl i_rx_stby_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_valid(rd_valid), .rd_data(rd_data), .ref_off(ref_off), .lo_off(lo_off),
    .osc_off(osc_off), .clksyn_off(clksyn_off), .gcdac_off(gcdac_off),
    .lnamix_off(lnamix_off), .adc_off(adc_off), .clkbuf_off(clkbuf_off),
    .filt_clk_en(filt_clk_en), .dout_hold(dout_hold), .master_ref_off(master_ref_off),
    .lo_iout_oe(lo_iout_oe), .clk_iout_oe(clk_iout_oe)
  );

  // Behavioural model, updated at the clock edge
  int m_word = 255;
  int m_rv = 0;
  int m_rd = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_word = 255; m_rv = 0; m_rd = 0;
    end else begin
      m_rv = rd_en ? 1 : 0;
      if (rd_en) m_rd = m_word;
      if (wr_en) m_word = int'(wr_data);
    end
  end

  function automatic int bitof(int v, int n);
    return (v / (1 << n)) % 2;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare every output against the model on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      automatic int all_used = (m_word % 2 == 1) && ((m_word / 4) == 63);
      automatic string rq = rst_n ? "R2" : "R1";
      chk(rq, "ref_off", int'(ref_off), bitof(m_word, 7));
      chk(rq, "lo_off", int'(lo_off), bitof(m_word, 6));
      chk(rq, "osc_off", int'(osc_off), bitof(m_word, 5));
      chk(rq, "clksyn_off", int'(clksyn_off), bitof(m_word, 4));
      chk(rq, "gcdac_off", int'(gcdac_off), bitof(m_word, 3));
      chk(rq, "lnamix_off", int'(lnamix_off), bitof(m_word, 2));
      chk(rq, "adc_off", int'(adc_off), bitof(m_word, 0));
      chk("R5", "clkbuf_off", int'(clkbuf_off),
          (bitof(m_word, 0) == 1 && bitof(m_word, 4) == 1) ? 1 : 0);
      chk("R6", "filt_clk_en", int'(filt_clk_en), 1 - bitof(m_word, 0));
      chk("R6", "dout_hold", int'(dout_hold), bitof(m_word, 0));
      chk("R7", "master_ref_off", int'(master_ref_off), all_used ? 1 : 0);
      chk("R8", "lo_iout_oe", int'(lo_iout_oe), 1 - bitof(m_word, 6));
      chk("R8", "clk_iout_oe", int'(clk_iout_oe), 1 - bitof(m_word, 4));
      chk("R3", "rd_valid", int'(rd_valid), m_rv);
      if (m_rv == 1) chk("R4", "rd_data", int'(rd_data), m_rd);
    end
  end

  task automatic cyc(bit w, logic [7:0] d, bit r);
    @(negedge clk);
    #1;
    wr_en = w; wr_data = d; rd_en = r;
  endtask

  initial begin
    int lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    cyc(0, 8'h00, 1);             // R1 reset value read back
    cyc(1, 8'hFD, 0);             // R9 only bit 1 cleared: no derived change
    cyc(0, 8'h00, 1);             // R9 read back bit 1
    cyc(1, 8'hFE, 0);             // R5 adc up, clock buffer on; R7 master up
    cyc(1, 8'hEF, 0);             // R5 clksyn up only
    cyc(1, 8'hFF, 0);             // R7 all standby again
    cyc(1, 8'h02, 1);             // R4 simultaneous read+write, old 0xFF returned
    cyc(1, 8'hBF, 1);             // R4 again, old 0x02 returned; R8 lo oe
    cyc(1, 8'h00, 0);             // R2 everything up
    cyc(1, 8'h55, 1);
    cyc(1, 8'hAA, 1);
    cyc(0, 8'h00, 0);
    cyc(0, 8'h00, 1);
    for (int i = 0; i < 300; i++) begin
      lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 16'hFFFF;
      cyc(lfsr[0], (lfsr[5:3] == 3'd0) ? 8'hFF : lfsr[15:8], lfsr[1] | lfsr[2]);
    end
    cyc(0, 8'h00, 0);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule